// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master for byte transfers with a one-deep transmit queue. Software writes a byte to the data address; the byte waits in a holding register until the shifter is free and then moves into it. While that byte shifts out, software may write the next byte. The engine starts the queued byte on the very next SCK half-period, so a burst of bytes leaves the pin as one continuous clock train.

Every byte that goes out brings a byte back from MISO. At the end of each byte the received value lands in a receive data register and a receive-full flag rises. Software clears that flag with a two-step handshake: a status read that sees the flag set, then a read of the data address. SCK idles low. Each bit is launched on the rising edge and captured on the falling edge. Bits go most significant first. The SCK rate is the system clock divided by an even number chosen on a static input.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset SCK and MOSI are low and `wr_collision` is low. A status read returns 0x08 and a data read returns 0x00.
- R2: A write to the data address (address 0) while transmit-empty is set is accepted, and transmit-empty reads 0. If the shifter is idle, the byte enters the shifter at the next clock edge. From then on transmit-empty (status bit 3) and busy (status bit 0) both read 1.
- R3: A write to the data address while the holding register is full is discarded and never reaches MOSI. It sets `wr_collision`, which stays set until reset.
- R4: SCK is low whenever no transfer is active. MOSI changes only together with a rising SCK edge. The byte appears on MOSI most significant bit first, one bit per SCK period.
- R5: A byte that is queued when the current byte completes starts with no gap. Its first rising SCK edge comes one full SCK period after the previous rising edge.
- R6: With `div_half` = N, each SCK phase lasts N+1 system clocks, so one SCK period is 2*(N+1) clocks (divisors 2 to 256).
- R7: When a byte completes, the eight MISO bits, sampled on the falling SCK edges (first bit most significant), go to the receive data register, and receive-full (status bit 7) is set.
- R8: Receive-full clears only when a status read (address 1) that saw it set is followed by a data read. A data read without that prior status read returns the byte and leaves the flag set.
- R9: A byte that completes while receive-full is set is dropped. The receive data register keeps the older byte and overrun (status bit 6) is set. The clearing sequence of R8 also clears overrun.
- R10: A read returns its data on `bus_rdata` one clock after the access. Status bits other than 7, 6, 3 and 0 read 0.
- R11: Busy reads 1 exactly while a byte is shifting. When idle, MOSI keeps the last bit it sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data, 1 = status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| div_half | input | 7 | SCK phase length minus one, in system clocks |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| wr_collision | output | 1 | Sticky flag: a write hit a full holding register |

## Verification
Read data is due one clock after the access edge. It shows the state before that edge, so a status read issued in the cycle after a data write returns 0x00: the byte is still in the holding register. The next status read returns 0x09, because the shifter took the byte at that edge. The bench drives the bus at falling clock edges and reads `bus_rdata` at the following falling edge. A monitor also runs on falling edges. It timestamps every SCK edge, requires 2*(N+1) clocks between rising edges both inside a byte and across a queued boundary, and pops the expected transmit byte from the scoreboard after the eighth falling edge. Receive flags are checked only after the monitor has counted the byte and three further clocks have passed.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  // Status bit positions (software decodes these)
  localparam int ST_RXF = 7;
  localparam int ST_OVR = 6;
  localparam int ST_TXE = 3;
  localparam int ST_BSY = 0;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_STAT = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIVW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] half_m1,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == half_m1) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == half_m1);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          miso,
  output logic          active,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int NPH = 2 * DW;
  localparam int PHW = $clog2(NPH);
  localparam logic [PHW-1:0] LAST_PH = PHW'(NPH - 1);

  logic [PHW-1:0] phase;
  logic [DW-1:0]  tx_sreg;
  logic [DW-1:0]  rx_sreg;

  assign done    = active && tick && (phase == LAST_PH);
  assign rx_byte = {rx_sreg[DW-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      tx_sreg <= '0;
      rx_sreg <= '0;
      active  <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      if (active && tick) begin
        phase <= phase + 1'b1;
        if (!phase[0]) begin
          // leading edge: launch next bit
          sck     <= 1'b1;
          mosi    <= tx_sreg[DW-1];
          tx_sreg <= {tx_sreg[DW-2:0], 1'b0};
        end else begin
          // trailing edge: capture input bit
          sck     <= 1'b0;
          rx_sreg <= {rx_sreg[DW-2:0], miso};
        end
      end
      if (load) begin
        tx_sreg <= load_data;
        phase   <= '0;
        active  <= 1'b1;
      end else if (done) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_dbuf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          we,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  input  logic          busy,
  output logic [DW-1:0] hold_data,
  output logic          hold_full,
  output logic          rx_full,
  output logic          rx_ovr,
  output logic [DW-1:0] rx_data,
  output logic [DW-1:0] rdata,
  output logic          wr_col
);
  logic          armed;
  logic          wr_hit, rd_data, rd_stat, rx_clr, rx_cap;
  logic [DW-1:0] stat;

  assign wr_hit  = sel && we && (addr == REG_DATA);
  assign rd_data = sel && !we && (addr == REG_DATA);
  assign rd_stat = sel && !we && (addr == REG_STAT);
  assign rx_clr  = rd_data && armed;
  assign rx_cap  = done && (!rx_full || rx_clr);

  always_comb begin
    stat         = '0;
    stat[ST_RXF] = rx_full;
    stat[ST_OVR] = rx_ovr;
    stat[ST_TXE] = !hold_full;
    stat[ST_BSY] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_full <= 1'b0;
      wr_col    <= 1'b0;
    end else begin
      if (wr_hit && !hold_full) begin
        hold_data <= wdata;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
      if (wr_hit && hold_full) wr_col <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (rx_cap) begin
        rx_data <= rx_byte;
        rx_full <= 1'b1;
      end else if (rx_clr) begin
        rx_full <= 1'b0;
      end
      if (done && rx_full && !rx_clr) rx_ovr <= 1'b1;
      else if (rx_clr) rx_ovr <= 1'b0;
      if (rx_clr) armed <= 1'b0;
      else if (rd_stat && rx_full) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (sel && !we) rdata <= (addr == REG_STAT) ? stat : rx_data;
  end
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int DW   = 8,
  parameter int DIVW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic            bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [DIVW-1:0] div_half,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic            wr_collision
);
  logic          busy, tick, done, take;
  logic          hold_full, rx_full, rx_ovr;
  logic [DW-1:0] hold_data, rx_data, rx_byte;

  assign take = hold_full && (!busy || done);

  spi_clk_div #(.DIVW(DIVW)) div_i (
    .clk(clk), .rst(rst), .run(busy), .half_m1(div_half), .tick(tick)
  );

  spi_shifter #(.DW(DW)) shf_i (
    .clk(clk), .rst(rst), .tick(tick), .load(take), .load_data(hold_data),
    .miso(miso), .active(busy), .sck(sck), .mosi(mosi), .done(done),
    .rx_byte(rx_byte)
  );

  spi_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .take(take), .done(done), .rx_byte(rx_byte),
    .busy(busy), .hold_data(hold_data), .hold_full(hold_full),
    .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_data(rx_data),
    .rdata(bus_rdata), .wr_col(wr_collision)
  );
endmodule

// File: rtl/spi_dbuf_master_chk.sv
module spi_dbuf_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_we,
  input logic          bus_addr,
  input logic          sck,
  input logic          mosi,
  input logic          wr_collision,
  input logic          busy,
  input logic          take,
  input logic          done,
  input logic          hold_full,
  input logic [DW-1:0] hold_data,
  input logic          rx_full,
  input logic          rx_ovr,
  input logic [DW-1:0] rx_data
);
  p_take_empties_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> !hold_full);

  p_wcol_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    wr_collision |=> wr_collision);

  p_wr_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && !bus_addr && hold_full) |=> (wr_collision && $stable(hold_data)));

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);

  p_mosi_edge_r4: assert property (@(posedge clk) disable iff (rst)
    !$rose(sck) |-> $stable(mosi));

  p_no_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (done && hold_full) |=> busy);

  p_rxf_set_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_full);

  p_rxf_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_full) |-> $past(bus_sel && !bus_we && !bus_addr));

  p_ovr_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (done && rx_full && !(bus_sel && !bus_we && !bus_addr)) |=> (rx_ovr && $stable(rx_data)));
endmodule

bind spi_dbuf_master spi_dbuf_master_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .sck(sck), .mosi(mosi), .wr_collision(wr_collision), .busy(busy),
  .take(take), .done(done), .hold_full(hold_full), .hold_data(hold_data),
  .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_data(rx_data)
);

// File: tb/spi_dbuf_master_tb_top.sv
module spi_dbuf_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [6:0] div_half = 7'd1;
  logic       sck, mosi, wr_collision;
  logic       miso = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] tx_exp[$];
  logic [7:0] slv_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dbuf_master dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_half(div_half),
    .sck(sck), .mosi(mosi), .miso(miso), .wr_collision(wr_collision)
  );

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: slave model, SCK timing and scoreboard pop
  logic       sck_q = 1'b0;
  int         cyc = 0, last_rise = 0, rise_n = 0, fall_n = 0, nbytes = 0;
  bit         b2b = 1'b0;
  logic [7:0] slv_cur = 8'h00, mon_sh = 8'h00;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (sck && !sck_q) begin
        if (rise_n == 0) begin
          slv_cur = (slv_q.size() != 0) ? slv_q.pop_front() : 8'h00;
          if (b2b) check_eq("R5 back-to-back rise spacing", cyc - last_rise, 2 * (int'(div_half) + 1));
        end else begin
          check_eq("R6 SCK period", cyc - last_rise, 2 * (int'(div_half) + 1));
        end
        last_rise = cyc;
        miso = slv_cur[7 - rise_n];
        rise_n = (rise_n + 1) % 8;
      end
      if (!sck && sck_q) begin
        mon_sh = {mon_sh[6:0], mosi};
        fall_n++;
        if (fall_n == 8) begin
          fall_n = 0;
          nbytes++;
          if (tx_exp.size() == 0) check_eq("R3 unexpected MOSI byte", int'(mon_sh), -1);
          else check_eq("R4 MOSI byte", int'(mon_sh), int'(tx_exp.pop_front()));
          b2b = (tx_exp.size() != 0);
        end
      end
    end
    sck_q = sck;
  end

  // Bus driver tasks: called at a falling edge, return at the next one
  task automatic bus_wr(input logic a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit accept);
    if (accept) tx_exp.push_back(d);
    bus_wr(1'b0, d);
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    bus_rd(a, v);
    check_eq(req, int'(v), int'(exp));
  endtask

  task automatic wait_bytes(input int n);
    while (nbytes < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_eq("R1 sck", int'(sck), 0);
    check_eq("R1 mosi", int'(mosi), 0);
    check_eq("R1 wr_collision", int'(wr_collision), 0);
    rd_chk(1'b1, 8'h08, "R1 status after reset");
    rd_chk(1'b0, 8'h00, "R1 R10 data after reset");

    // Single byte, divisor 4
    div_half = 7'd1;
    slv_q.push_back(8'h3C);
    send(8'hA5, 1'b1);
    rd_chk(1'b1, 8'h00, "R2 status one cycle after write");
    rd_chk(1'b1, 8'h09, "R2 R11 status after shifter load");
    wait_bytes(1);
    check_eq("R11 mosi holds last bit", int'(mosi), 1);
    rd_chk(1'b1, 8'h88, "R7 R10 status after byte");
    rd_chk(1'b0, 8'h3C, "R7 received byte");
    rd_chk(1'b1, 8'h08, "R8 flag cleared by sequence");

    // Data read without prior status read keeps the flag
    slv_q.push_back(8'hC3);
    send(8'h5A, 1'b1);
    wait_bytes(2);
    rd_chk(1'b0, 8'hC3, "R8 data read unarmed");
    rd_chk(1'b1, 8'h88, "R8 flag still set");
    rd_chk(1'b0, 8'hC3, "R8 armed data read");
    rd_chk(1'b1, 8'h08, "R8 flag cleared");

    // Queued byte, rejected write, overrun, divisor 2
    div_half = 7'd0;
    slv_q.push_back(8'h11);
    slv_q.push_back(8'h22);
    send(8'h96, 1'b1);
    @(negedge clk);
    send(8'h4D, 1'b1);
    send(8'hFF, 1'b0);
    check_eq("R3 wr_collision set", int'(wr_collision), 1);
    rd_chk(1'b1, 8'h01, "R2 R3 status while queued");
    wait_bytes(4);
    check_eq("R3 rejected byte not sent", nbytes, 4);
    rd_chk(1'b1, 8'hC8, "R9 overrun status");
    rd_chk(1'b0, 8'h11, "R9 older byte kept");
    rd_chk(1'b1, 8'h08, "R9 overrun cleared");
    check_eq("R3 wr_collision sticky", int'(wr_collision), 1);

    // Largest divisor 256
    div_half = 7'd127;
    slv_q.push_back(8'h81);
    send(8'h7E, 1'b1);
    wait_bytes(5);
    check_eq("R11 mosi holds last bit 0", int'(mosi), 0);
    rd_chk(1'b1, 8'h88, "R7 status slow byte");
    rd_chk(1'b0, 8'h81, "R7 slow byte received");
    rd_chk(1'b1, 8'h08, "R8 cleared slow byte");

    // Divisor 10
    div_half = 7'd4;
    slv_q.push_back(8'h0F);
    send(8'hC1, 1'b1);
    wait_bytes(6);
    check_eq("R11 mosi idle value", int'(mosi), 1);
    check_eq("R4 sck idle", int'(sck), 0);
    rd_chk(1'b1, 8'h88, "R7 status divisor 10");
    rd_chk(1'b0, 8'h0F, "R7 byte divisor 10");
    check_eq("R4 scoreboard empty", tx_exp.size(), 0);

    summary();
    $finish;
  end
endmodule